// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a slave on an SMBus/I2C two-wire bus. It lets a host reach a small bank of 8-bit configuration registers in blocks. To write, the host sends the write address, a starting register index, a byte count, and then that many data bytes. To read, the host first sends the write address and the starting index. It then issues a repeated start and the read address. The slave replies with a byte count, which it takes from a count register that the host can program, and then streams register contents beginning at the index.

The bus lines come in as plain levels. The slave pulls SDA low through a drive-low enable, which models an open-drain output. A parallel port also reads and writes the same register bank, so that on-chip logic sees and sets the configuration.

Top module: `smb_idx_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). After any other address byte it drives nothing and acknowledges no byte until the next start condition.
- R2: In a write, the slave acknowledges the index byte, the count byte and each data byte within the count. Data byte k is stored at register (index + k).
- R3: Data bytes sent after the count is used up are not acknowledged and are not stored. A count of zero stores nothing.
- R4: In a read, the first byte sent is the current value of the count register, which is register REGS-1 (register 15 by default). Register bytes follow from the index onward for as long as the host acknowledges. A not-acknowledge ends the transmission and releases SDA.
- R5: Only the low log2(REGS) bits of the index byte are used. The register pointer advances by one after each byte, and after the last register it wraps to register 0.
- R6: A start or stop condition that arrives in the middle of a byte abandons the current transfer. Registers stored before it keep their values. A start always begins a new address phase.
- R7: The slave changes its SDA drive only while SCL is low. A falling SDA edge while SCL is high is a start, and a rising SDA edge while SCL is high is a stop.
- R8: Each write byte is committed to the bank while SCL is low, when the slave begins driving that byte's acknowledge. The parallel port writes reg_wdata to reg_addr when reg_we is high. reg_rdata shows the register at reg_addr one clock after the address is presented. If both sides write in the same clock, the bus write wins.
- R9: After reset, SDA is released and every register, including the count register, reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_we | input | 1 | Parallel write strobe |
| reg_addr | input | log2(REGS) | Parallel register address |
| reg_wdata | input | 8 | Parallel write data |
| reg_rdata | output | 8 | Parallel read data, registered |

## Verification
The hardest situation to reach is a transfer that is cut short: a stop or a start placed a few bits into a byte, after earlier bytes of the same block were already committed. The bench reaches it with a bit-level host. That host can emit a partial byte and then a bus condition, and it follows with a fresh transaction to show that the slave recovers. Wrapping past the last register is the other rare case. The bench drives it with an index byte whose upper bits are set and whose block crosses the top of the bank, in both directions. After every transaction, a pipelined sweep of the parallel port compares each clock's read data with the bench's own register image.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_HOLD
  } smb_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_COUNT,
    RL_DATA
  } smb_role_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic            scl_p, sda_p;
  logic            scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_in};
      sda_q <= {sda_q[SYNC-2:0], sda_in};
      scl_p <= scl_q[SYNC-1];
      sda_p <= sda_q[SYNC-1];
    end
  end

  assign scl_s     = scl_q[SYNC-1];
  assign sda_s     = sda_q[SYNC-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA edges count as conditions only while SCL stays high across both samples.
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int REGS    = 16,
  parameter int CNT_IDX = REGS - 1,
  localparam int AW     = $clog2(REGS),
  localparam int DW     = smb_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_idx,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] ptr_idx,
  output logic [DW-1:0] ptr_rdata,
  output logic [DW-1:0] cnt_rdata,
  input  logic          par_we,
  input  logic [AW-1:0] par_addr,
  input  logic [DW-1:0] par_wdata,
  output logic [DW-1:0] par_rdata
);
  logic [DW-1:0] mem [REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) mem[i] <= '0;
    end else if (bus_we) begin
      mem[bus_idx] <= bus_wdata;
    end else if (par_we) begin
      mem[par_addr] <= par_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) par_rdata <= '0;
    else     par_rdata <= mem[par_addr];
  end

  assign ptr_rdata = mem[ptr_idx];
  assign cnt_rdata = mem[CNT_IDX];
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_pkg::*;
#(
  parameter int          REGS    = 16,
  parameter logic [7:0]  WR_ADDR = 8'hD2,
  parameter logic [7:0]  RD_ADDR = 8'hD3,
  localparam int         AW      = $clog2(REGS),
  localparam int         DW      = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] ptr_rdata,
  input  logic [DW-1:0] cnt_rdata,
  output logic          sda_oe,
  output logic          bus_we,
  output logic [AW-1:0] bus_idx,
  output logic [DW-1:0] bus_wdata,
  output logic [AW-1:0] ptr_idx
);
  smb_state_e    state;
  smb_role_e     role;
  logic [3:0]    bitcnt;
  logic [DW-1:0] sreg;
  logic [DW-1:0] remain;
  logic          go_tx;
  logic          host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      role      <= RL_ADDR;
      bitcnt    <= '0;
      sreg      <= '0;
      remain    <= '0;
      go_tx     <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      bus_we    <= 1'b0;
      bus_idx   <= '0;
      bus_wdata <= '0;
      ptr_idx   <= '0;
    end else begin
      bus_we <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        role   <= RL_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sreg   <= {sreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              go_tx  <= 1'b0;
              unique case (role)
                RL_ADDR: begin
                  if (sreg == WR_ADDR) begin
                    role   <= RL_INDEX;
                    sda_oe <= 1'b1;
                    state  <= ST_RXACK;
                  end else if (sreg == RD_ADDR) begin
                    go_tx  <= 1'b1;
                    sda_oe <= 1'b1;
                    state  <= ST_RXACK;
                  end else begin
                    state  <= ST_HOLD;
                  end
                end
                RL_INDEX: begin
                  ptr_idx <= sreg[AW-1:0];
                  role    <= RL_COUNT;
                  sda_oe  <= 1'b1;
                  state   <= ST_RXACK;
                end
                RL_COUNT: begin
                  remain <= sreg;
                  role   <= RL_DATA;
                  sda_oe <= 1'b1;
                  state  <= ST_RXACK;
                end
                RL_DATA: begin
                  if (remain != '0) begin
                    bus_we    <= 1'b1;
                    bus_idx   <= ptr_idx;
                    bus_wdata <= sreg;
                    ptr_idx   <= ptr_idx + 1'b1;
                    remain    <= remain - 1'b1;
                    sda_oe    <= 1'b1;
                    state     <= ST_RXACK;
                  end else begin
                    state <= ST_HOLD;
                  end
                end
                default: state <= ST_HOLD;
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (go_tx) begin
                sreg   <= cnt_rdata;
                sda_oe <= ~cnt_rdata[DW-1];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                sreg   <= {sreg[DW-2:0], 1'b0};
                sda_oe <= ~sreg[DW-2];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                sreg    <= ptr_rdata;
                sda_oe  <= ~ptr_rdata[DW-1];
                ptr_idx <= ptr_idx + 1'b1;
                bitcnt  <= '0;
                state   <= ST_TX;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave #(
  parameter int         REGS        = 16,
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(REGS),
  localparam int        DW          = smb_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          bus_we;
  logic [AW-1:0] bus_idx, ptr_idx;
  logic [DW-1:0] bus_wdata, ptr_rdata, cnt_rdata;

  smb_line_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_proto_fsm #(.REGS(REGS), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ptr_rdata(ptr_rdata), .cnt_rdata(cnt_rdata), .sda_oe(sda_oe),
    .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .ptr_idx(ptr_idx)
  );

  smb_reg_bank #(.REGS(REGS), .CNT_IDX(REGS - 1)) u_bank (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .ptr_idx(ptr_idx), .ptr_rdata(ptr_rdata),
    .cnt_rdata(cnt_rdata), .par_we(reg_we), .par_addr(reg_addr),
    .par_wdata(reg_wdata), .par_rdata(reg_rdata)
  );
endmodule

// File: rtl/smb_idx_chk.sv
module smb_idx_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          bus_we,
  input logic [AW-1:0] bus_idx,
  input logic [AW-1:0] ptr_idx
);
  // R7: the SDA drive moves only while SCL is low
  assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_in);

  // R9: SDA is released when reset ends
  assert_released_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_oe);

  // R8: the bank commit lands while SCL is low
  assert_commit_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> !scl_in);

  // R5: the pointer is one past the committed register, modulo the bank size
  assert_ptr_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> (ptr_idx == AW'(bus_idx + 1'b1)));

  // R8: a commit is followed by the slave pulling SDA for the acknowledge
  assert_commit_then_ack_R8: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> sda_oe);
endmodule

bind smb_idx_slave smb_idx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .bus_we(bus_we), .bus_idx(bus_idx), .ptr_idx(ptr_idx)
);

// File: tb/smb_idx_slave_tb.sv
module smb_idx_slave_tb;
  localparam int REGS = 16;
  localparam int AW   = 4;
  localparam int Q    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_h = 1'b1;
  logic          sda_h = 1'b1;
  logic          sda_oe;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  wire           sda_line = sda_h & ~sda_oe;

  logic [7:0] exp_mem [REGS];
  int tests = 0;
  int fails = 0;
  int sda_viol = 0;
  logic oe_q = 1'b0;
  logic scl_q = 1'b1;

  always #10 clk = ~clk;

  smb_idx_slave u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_h), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // R7 monitor: values seen just before each edge
  always @(posedge clk) begin
    if (!rst && scl_h && scl_q && (sda_oe != oe_q)) sda_viol++;
    oe_q  = sda_oe;
    scl_q = scl_h;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b0; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_h = b; wq();
    scl_h = 1'b1; wq();
    r = sda_line; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      b[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  // Pipelined parallel sweep: register image compared on each clock.
  task automatic sweep(input string req);
    int bad = 0;
    int first_a = -1;
    logic [7:0] first_v = '0;
    for (int i = 0; i <= REGS; i++) begin
      @(negedge clk);
      if (i > 0 && reg_rdata !== exp_mem[i-1]) begin
        bad++;
        if (first_a < 0) begin first_a = i - 1; first_v = reg_rdata; end
      end
      if (i < REGS) reg_addr = AW'(i);
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s reg%0d actual=%0h expected=%0h", req, first_a,
               first_v, exp_mem[first_a]);
    end
  endtask

  task automatic w_ack(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    wbyte(b, a);
    chk(req, int'(a), int'(exp_ack));
  endtask

  task automatic r_chk(input logic give_ack, input logic [7:0] exp_b, input string req);
    logic [7:0] b;
    rbyte(give_ack, b);
    chk(req, int'(b), int'(exp_b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic r;
    for (int i = 0; i < REGS; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sda released", int'(sda_oe), 0);
    sweep("R9 reset image");

    // R1, R2: block write at index 2
    bus_start();
    w_ack(8'hD2, 1'b1, "R1 write addr ack");
    w_ack(8'h02, 1'b1, "R2 index ack");
    w_ack(8'h03, 1'b1, "R2 count ack");
    w_ack(8'hA1, 1'b1, "R2 data ack");
    w_ack(8'hB2, 1'b1, "R2 data ack");
    w_ack(8'hC3, 1'b1, "R2 data ack");
    bus_stop();
    exp_mem[2] = 8'hA1; exp_mem[3] = 8'hB2; exp_mem[4] = 8'hC3;
    sweep("R2 block write");

    // R3: byte past the count refused
    bus_start();
    w_ack(8'hD2, 1'b1, "R3 addr");
    w_ack(8'h05, 1'b1, "R3 index");
    w_ack(8'h01, 1'b1, "R3 count");
    w_ack(8'h77, 1'b1, "R3 in-count byte");
    w_ack(8'h88, 1'b0, "R3 excess byte nack");
    bus_stop();
    exp_mem[5] = 8'h77;
    sweep("R3 excess not stored");

    // R5: index upper bits dropped, write crosses the top
    bus_start();
    w_ack(8'hD2, 1'b1, "R5 addr");
    w_ack(8'h1E, 1'b1, "R5 index");
    w_ack(8'h03, 1'b1, "R5 count");
    w_ack(8'h90, 1'b1, "R5 data");
    w_ack(8'h03, 1'b1, "R5 data to count reg");
    w_ack(8'h44, 1'b1, "R5 data wrapped");
    bus_stop();
    exp_mem[14] = 8'h90; exp_mem[15] = 8'h03; exp_mem[0] = 8'h44;
    sweep("R5 wrapped write");

    // R4: block read from index 2, count from register 15
    bus_start();
    w_ack(8'hD2, 1'b1, "R4 addr");
    w_ack(8'h02, 1'b1, "R4 index");
    bus_start();
    w_ack(8'hD3, 1'b1, "R4 read addr ack");
    r_chk(1'b1, 8'h03, "R4 count byte");
    r_chk(1'b1, 8'hA1, "R4 data0");
    r_chk(1'b1, 8'hB2, "R4 data1");
    r_chk(1'b0, 8'hC3, "R4 data2");
    chk("R4 released after nack", int'(sda_oe), 0);
    bus_stop();

    // R5: read crosses the top of the bank
    bus_start();
    w_ack(8'hD2, 1'b1, "R5 read addr");
    w_ack(8'h0F, 1'b1, "R5 read index");
    bus_start();
    w_ack(8'hD3, 1'b1, "R5 read ack");
    r_chk(1'b1, 8'h03, "R5 count");
    r_chk(1'b1, 8'h03, "R5 reg15");
    r_chk(1'b1, 8'h44, "R5 reg0 wrapped");
    r_chk(1'b0, 8'h00, "R5 reg1");
    bus_stop();

    // R1: foreign address ignored until next start
    bus_start();
    w_ack(8'hA0, 1'b0, "R1 foreign addr nack");
    w_ack(8'h07, 1'b0, "R1 ignored byte");
    w_ack(8'h01, 1'b0, "R1 ignored byte");
    w_ack(8'hEE, 1'b0, "R1 ignored byte");
    bus_stop();
    sweep("R1 nothing stored");

    // R6: stop inside a byte
    bus_start();
    w_ack(8'hD2, 1'b1, "R6 addr");
    w_ack(8'h08, 1'b1, "R6 index");
    w_ack(8'h04, 1'b1, "R6 count");
    w_ack(8'h11, 1'b1, "R6 data");
    w_ack(8'h22, 1'b1, "R6 data");
    bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b1, r);
    bus_stop();
    exp_mem[8] = 8'h11; exp_mem[9] = 8'h22;
    sweep("R6 stop abort keeps earlier bytes");

    // R6: start inside a byte, then a new transfer
    bus_start();
    w_ack(8'hD2, 1'b1, "R6 addr2");
    w_ack(8'h00, 1'b1, "R6 index2");
    w_ack(8'h02, 1'b1, "R6 count2");
    w_ack(8'h55, 1'b1, "R6 data2");
    bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b1, r); bus_bit(1'b0, r);
    bus_start();
    w_ack(8'hD2, 1'b1, "R6 addr after restart");
    w_ack(8'h0C, 1'b1, "R6 index after restart");
    w_ack(8'h01, 1'b1, "R6 count after restart");
    w_ack(8'h66, 1'b1, "R6 data after restart");
    bus_stop();
    exp_mem[0] = 8'h55; exp_mem[12] = 8'h66;
    sweep("R6 start abort");

    // R8: parallel write then registered read
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h5A;
    @(negedge clk);
    reg_we = 1'b0;
    exp_mem[3] = 8'h5A;
    @(negedge clk);
    chk("R8 parallel readback", int'(reg_rdata), 8'h5A);
    sweep("R8 image after parallel write");

    chk("R7 sda moved with scl high", sda_viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule